// File: doc/BRIEF.md
# Multi-Lane Trace Gate with Cross-Trigger Match

This block sits between up to eight parallel trace sources and a trace packer inside a multi-lane monitor. Each lane delivers a valid strobe and a data word every clock. A lane's element is passed on, registered, only when a master switch is on and that lane's own switch is on. Otherwise the lane's output valid stays low and its output data stays zero.

One lane at a time can be chosen as the cross-trigger source. A valid, forwarded element on that lane is compared against a programmable pattern under a programmable mask. Each match produces a one-cycle pulse on the cross-trigger output, aligned with the forwarded element. A build parameter fixes how many lanes are implemented. The enable bits of absent lanes are held at zero, so those lanes never forward anything and never trigger.

Software programs the block through a small synchronous write port with combinational read-back. Address 0 is the control word, address 1 the pattern and address 2 the mask. Address 3 reads as zero.

Top module: `lgate_top`

## Requirements
- R1: After synchronous reset the control word reads 0, the pattern and mask read 0, every output valid is 0, every output data word is 0 and the cross-trigger is 0.
- R2: Control word at address 0: bit 0 is the master enable, bits 15:8 are the lane enables (bit 8+n for lane n) and bits 18:16 select the cross-trigger lane. Every other bit reads 0.
- R3: Lane-enable bits for lanes at or above NUM_LANES read back as 0 after any write, and those lanes never assert their output valid.
- R4: Output valid of lane n is 1 in the cycle after the lane's input valid was 1 while the master enable and lane-enable n were both 1, and is 0 otherwise.
- R5: Output data of lane n equals the input data of the previous cycle when its output valid is 1, and is zero when its output valid is 0.
- R6: The pattern (address 1) and the mask (address 2) store the low DATA_W bits written and read them back zero-extended.
- R7: The cross-trigger pulses for exactly one cycle, one cycle after an element is forwarded on the selected lane whose data equals the pattern in every bit where the mask is 1.
- R8: Data bits whose mask bit is 0 are ignored by the match, so an all-zero mask matches every forwarded element of the selected lane.
- R9: When the select field names a lane at or above NUM_LANES, the cross-trigger never pulses.
- R10: A matching element on a lane other than the selected one, or on a selected lane that is disabled or not valid, does not pulse the cross-trigger.
- R11: With the master enable at 0, no lane forwards anything, whatever the lane enables hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read-back of the addressed register |
| lane_valid_i | input | 8 | Per-lane input valid |
| lane_data_i | input | 8*DATA_W | Per-lane input data, lane n at bits n*DATA_W upward |
| trc_valid_o | output | 8 | Per-lane forwarded valid |
| trc_data_o | output | 8*DATA_W | Per-lane forwarded data, zero when not valid |
| xtrig_o | output | 1 | Cross-trigger match pulse |

## Verification
A corrupted enable or select state shows at the ports within one cycle. A wrong lane enable either drops or leaks a forwarded element on the following cycle. A wrong select bit either misses a trigger pulse or fires a spurious one on the same cycle as the forwarded element. Stored enable bits for absent lanes show up immediately in the address 0 read-back. A bad pattern or mask bit stays hidden until an element that differs in exactly that bit reaches the selected lane. For that reason the vectors place near-miss values on the selected lane, with the matching value on neighbouring lanes.

// File: rtl/lgate_pkg.sv
package lgate_pkg;

    localparam int MAX_LANES = 8;
    localparam int SEL_W     = 3;
    localparam int REG_W     = 32;
    localparam int EN_LSB    = 8;
    localparam int SEL_LSB   = 16;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_PAT  = 2'd1,
        A_MASK = 2'd2,
        A_RSVD = 2'd3
    } addr_e;

    typedef struct packed {
        logic [SEL_W-1:0]     xsel;
        logic [MAX_LANES-1:0] lane_en;
        logic                 glb;
    } ctrl_t;

    function automatic logic [MAX_LANES-1:0] impl_mask(input int n);
        logic [MAX_LANES-1:0] m;
        for (int i = 0; i < MAX_LANES; i++) m[i] = (i < n);
        return m;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[0] = c.glb;
        w[EN_LSB +: MAX_LANES] = c.lane_en;
        w[SEL_LSB +: SEL_W] = c.xsel;
        return w;
    endfunction

endpackage

// File: rtl/lgate_regs.sv
module lgate_regs
    import lgate_pkg::*;
#(
    parameter int NUM_LANES = 6,
    parameter int DATA_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] pat,
    output logic [DATA_W-1:0] mask
);
    localparam logic [MAX_LANES-1:0] IMPL = impl_mask(NUM_LANES);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            pat  <= '0;
            mask <= '0;
        end else if (we) begin
            case (addr_e'(addr))
                A_CTRL: begin
                    ctrl.glb     <= wdata[0];
                    ctrl.lane_en <= wdata[EN_LSB +: MAX_LANES] & IMPL;
                    ctrl.xsel    <= wdata[SEL_LSB +: SEL_W];
                end
                A_PAT:  pat  <= wdata[DATA_W-1:0];
                A_MASK: mask <= wdata[DATA_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr_e'(addr))
            A_CTRL:  rdata = pack_ctrl(ctrl);
            A_PAT:   rdata = REG_W'(pat);
            A_MASK:  rdata = REG_W'(mask);
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/lgate_lane.sv
module lgate_lane #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              open_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            data_o  <= '0;
        end else begin
            valid_o <= valid_i & open_i;
            data_o  <= (valid_i & open_i) ? data_i : '0;
        end
    end
endmodule

// File: rtl/lgate_xmatch.sv
module lgate_xmatch
    import lgate_pkg::*;
#(
    parameter int NUM_LANES = 6,
    parameter int DATA_W    = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [MAX_LANES-1:0]          fwd_i,
    input  logic [MAX_LANES*DATA_W-1:0]   data_i,
    input  logic [SEL_W-1:0]              sel_i,
    input  logic [DATA_W-1:0]             pat_i,
    input  logic [DATA_W-1:0]             mask_i,
    output logic                          xtrig_o
);
    logic              sel_ok;
    logic [DATA_W-1:0] sel_data;
    logic              hit;

    assign sel_ok   = int'(sel_i) < NUM_LANES;
    assign sel_data = data_i[sel_i*DATA_W +: DATA_W];
    assign hit      = sel_ok && fwd_i[sel_i] && (((sel_data ^ pat_i) & mask_i) == '0);

    always_ff @(posedge clk) begin
        if (rst) xtrig_o <= 1'b0;
        else     xtrig_o <= hit;
    end
endmodule

// File: rtl/lgate_top.sv
module lgate_top
    import lgate_pkg::*;
#(
    parameter int NUM_LANES = 6,
    parameter int DATA_W    = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        reg_we,
    input  logic [1:0]                  reg_addr,
    input  logic [31:0]                 reg_wdata,
    output logic [31:0]                 reg_rdata,
    input  logic [7:0]                  lane_valid_i,
    input  logic [8*DATA_W-1:0]         lane_data_i,
    output logic [7:0]                  trc_valid_o,
    output logic [8*DATA_W-1:0]         trc_data_o,
    output logic                        xtrig_o
);
    ctrl_t                ctrl;
    logic [DATA_W-1:0]    pat;
    logic [DATA_W-1:0]    mask;
    logic [MAX_LANES-1:0] open_v;
    logic [SEL_W-1:0]     xsel;

    assign xsel   = ctrl.xsel;
    assign open_v = ctrl.glb ? ctrl.lane_en : '0;

    lgate_regs #(.NUM_LANES(NUM_LANES), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .ctrl(ctrl), .pat(pat), .mask(mask)
    );

    for (genvar n = 0; n < MAX_LANES; n++) begin : g_lane
        if (n < NUM_LANES) begin : g_impl
            lgate_lane #(.DATA_W(DATA_W)) u_lane (
                .clk(clk), .rst(rst), .open_i(open_v[n]),
                .valid_i(lane_valid_i[n]),
                .data_i(lane_data_i[n*DATA_W +: DATA_W]),
                .valid_o(trc_valid_o[n]),
                .data_o(trc_data_o[n*DATA_W +: DATA_W])
            );
        end else begin : g_absent
            assign trc_valid_o[n] = 1'b0;
            assign trc_data_o[n*DATA_W +: DATA_W] = '0;
        end
    end

    lgate_xmatch #(.NUM_LANES(NUM_LANES), .DATA_W(DATA_W)) u_xm (
        .clk(clk), .rst(rst),
        .fwd_i(lane_valid_i & open_v), .data_i(lane_data_i),
        .sel_i(ctrl.xsel), .pat_i(pat), .mask_i(mask),
        .xtrig_o(xtrig_o)
    );
endmodule

// File: rtl/lgate_chk.sv
module lgate_chk
    import lgate_pkg::*;
#(
    parameter int NUM_LANES = 6
) (
    input logic                 clk,
    input logic                 rst,
    input logic [7:0]           lane_valid_i,
    input logic [7:0]           trc_valid_o,
    input logic                 xtrig_o,
    input logic [SEL_W-1:0]     xsel
);
    localparam logic [7:0] IMPL = impl_mask(NUM_LANES);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        $past(rst) |-> (trc_valid_o == 8'h00 && !xtrig_o));

    // R4
    fwd_needs_input_chk: assert property (@(posedge clk) disable iff (rst)
        (trc_valid_o & ~$past(lane_valid_i)) == 8'h00);

    // R3
    absent_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (trc_valid_o & ~IMPL) == 8'h00);

    // R7
    xtrig_with_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        xtrig_o |-> (trc_valid_o != 8'h00));

    // R9
    xtrig_impl_sel_chk: assert property (@(posedge clk) disable iff (rst)
        xtrig_o |-> ({1'b0, $past(xsel)} < 4'(NUM_LANES)));
endmodule

bind lgate_top lgate_chk #(.NUM_LANES(NUM_LANES)) u_chk (
    .clk(clk), .rst(rst), .lane_valid_i(lane_valid_i),
    .trc_valid_o(trc_valid_o), .xtrig_o(xtrig_o), .xsel(xsel)
);

// File: tb/tb_lgate_top.sv
module tb_lgate_top;
    localparam int DW = 16;

    logic            clk = 1'b0;
    logic            rst;
    logic            reg_we;
    logic [1:0]      reg_addr;
    logic [31:0]     reg_wdata;
    logic [31:0]     reg_rdata;
    logic [7:0]      lane_valid_i;
    logic [8*DW-1:0] lane_data_i;
    logic [7:0]      trc_valid_o;
    logic [8*DW-1:0] trc_data_o;
    logic            xtrig_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    lgate_top #(.NUM_LANES(6), .DATA_W(DW)) dut (.*);

    typedef struct packed {
        logic [31:0] ctrl;
        logic [7:0]  valid;
        logic [15:0] base;
        logic [7:0]  expv;
        logic        expx;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{32'h0002FF01, 8'hFF, 16'h1233, 8'h3F, 1'b1},
        '{32'h0002FF00, 8'hFF, 16'h1233, 8'h00, 1'b0},
        '{32'h00000501, 8'hFF, 16'h1235, 8'h05, 1'b1},
        '{32'h00010501, 8'hFF, 16'h1234, 8'h05, 1'b0},
        '{32'h00063F01, 8'hFF, 16'h122F, 8'h3F, 1'b0},
        '{32'h00033F01, 8'h37, 16'h1232, 8'h37, 1'b0},
        '{32'h00033F01, 8'h08, 16'h1232, 8'h08, 1'b1},
        '{32'h00043F01, 8'h10, 16'h1232, 8'h10, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input string req, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic drive(input logic [7:0] v, input logic [15:0] base);
        lane_valid_i = v;
        for (int n = 0; n < 8; n++) lane_data_i[n*DW +: DW] = base + 16'(n);
        @(negedge clk);
        lane_valid_i = 8'h00;
    endtask

    task automatic fwd_lane0(input logic [15:0] d);
        lane_valid_i = 8'h01;
        lane_data_i[DW-1:0] = d;
        @(negedge clk);
        lane_valid_i = 8'h00;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
        lane_valid_i = '0; lane_data_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, "R1 ctrl", 32'h0);
        rd(2'd1, "R1 pat", 32'h0);
        rd(2'd2, "R1 mask", 32'h0);
        check("R1 valid", 32'(trc_valid_o), 32'h0);
        check("R1 data", 32'(|trc_data_o), 32'h0);
        check("R1 xtrig", 32'(xtrig_o), 32'h0);

        // R2 R3 control read-back with absent-lane bits dropped
        wr(2'd0, 32'hFFFFFFFF);
        rd(2'd0, "R2 R3 ctrl readback", 32'h00073F01);
        // R6 pattern and mask, upper bits dropped
        wr(2'd1, 32'hABCD1235);
        rd(2'd1, "R6 pat", 32'h00001235);
        wr(2'd2, 32'h0000FFFF);
        rd(2'd2, "R6 mask", 32'h0000FFFF);
        rd(2'd3, "R2 reserved addr", 32'h0);

        // Table: R4 R5 R7 R9 R10 R11
        for (int i = 0; i < 8; i++) begin
            wr(2'd0, VECS[i].ctrl);
            drive(VECS[i].valid, VECS[i].base);
            check($sformatf("R4 R11 R3 valid v%0d", i), 32'(trc_valid_o), 32'(VECS[i].expv));
            check($sformatf("R7 R9 R10 xtrig v%0d", i), 32'(xtrig_o), 32'(VECS[i].expx));
            for (int n = 0; n < 8; n++)
                check($sformatf("R5 data v%0d lane%0d", i, n),
                      32'(trc_data_o[n*DW +: DW]),
                      VECS[i].expv[n] ? 32'(VECS[i].base + 16'(n)) : 32'h0);
            @(negedge clk);
            check($sformatf("R7 pulse ends v%0d", i), 32'(xtrig_o), 32'h0);
        end

        // R8 partial mask on lane 0
        wr(2'd0, 32'h00000101);
        wr(2'd1, 32'h00000030);
        wr(2'd2, 32'h000000F0);
        fwd_lane0(16'hAB3C);
        check("R8 masked match", 32'(xtrig_o), 32'h1);
        fwd_lane0(16'hAB4C);
        check("R8 masked miss", 32'(xtrig_o), 32'h0);
        wr(2'd2, 32'h0);
        fwd_lane0(16'h5A5A);
        check("R8 zero mask", 32'(xtrig_o), 32'h1);

        // R1 reset again mid-traffic
        lane_valid_i = 8'h01;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; lane_valid_i = 8'h00;
        check("R1 re-reset valid", 32'(trc_valid_o), 32'h0);
        rd(2'd0, "R1 re-reset ctrl", 32'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule